// File: doc/BRIEF.md
# Memory Request Queue with Backlog Bypass

This block sits between a memory arbiter and a DDR controller and holds burst requests that have already won arbitration. Each burst is marked as CPU or DMA traffic. DMA bursts also carry a transaction number. The controller always takes the burst at the head of a short in-order queue. A newly granted CPU burst would otherwise wait behind every DMA burst already queued. To avoid that wait, the block can pull queued DMA bursts out into a side backlog buffer, and the CPU burst then lands directly behind the head.

Bursts parked in the backlog return to the queue in their original order. They return on every cycle in which the arbiter is not presenting a CPU burst and the queue has room. While the backlog holds anything, fresh DMA bursts from the arbiter are refused, so backlogged bursts are always granted before new DMA traffic. Two plain control pins drive the feature: one enables the bypass, and the other says that CPU traffic ranks above DMA. With the bypass disabled, the block is an ordinary FIFO.

Both data sides use valid/ready handshakes. A burst moves when valid and ready are high at the same rising edge. The input side raises `in_ready` combinationally from the queue state, `in_is_cpu` and `in_valid`. It does not depend on `out_ready`. A presented burst must stay stable until it is accepted. The output side holds `out_valid` and the head fields steady until `out_ready` is seen.

Top module: `mrq_bypass_queue`

## Requirements
- R1: After reset the queue and backlog are empty, `out_valid` is low, and `in_ready` is high for a presented DMA burst.
- R2: With `cfg_bypass_en` low, the block is a first-in first-out queue of DEPTH (default 5) bursts. It delivers them in arrival order, and when it holds DEPTH bursts, `in_ready` is low for any burst.
- R3: While `out_valid` is high and `out_ready` is low, the head burst (`out_is_cpu`, `out_id`, `out_addr`) stays unchanged. At most one burst enters and one burst leaves per cycle.
- R4: A move happens when `cfg_bypass_en` and `cfg_cpu_first` are both high, a CPU burst (`in_is_cpu`=1) is presented, and the backlog is empty. In that cycle, every eligible DMA burst behind the head leaves the queue in order, and the CPU burst takes the first free slot.
- R5: A DMA burst is eligible only if it is not at the head and its `id` differs from the head's `id` whenever the head is a DMA burst. Bursts sharing the head's transaction stay in the queue.
- R6: With `cfg_cpu_first` low, no move happens, and a CPU burst queues behind all earlier DMA bursts.
- R7: No move happens while the backlog holds any burst. A CPU burst then simply joins the queue tail.
- R8: While the backlog holds any burst, `in_ready` is low for a presented DMA burst.
- R9: A presented CPU burst sees `in_ready` high whenever the queue holds fewer than DEPTH bursts. It sees `in_ready` low when the queue is full and no move is possible.
- R10: On each cycle without a presented CPU burst, if the backlog is non-empty and the queue has room, the oldest backlog burst enters the queue tail. Backlog bursts return in the order they were queued.
- R11: A CPU burst presented to a full queue is accepted in the same cycle when a move frees at least one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass_en | input | 1 | Enables moving DMA bursts to the backlog |
| cfg_cpu_first | input | 1 | High when CPU traffic ranks above DMA |
| in_valid | input | 1 | Arbiter presents a granted burst |
| in_ready | output | 1 | Block accepts the presented burst |
| in_is_cpu | input | 1 | 1 = CPU burst, 0 = DMA burst |
| in_id | input | 4 | DMA transaction number |
| in_addr | input | 16 | Burst address |
| out_valid | output | 1 | Head burst available to the controller |
| out_ready | input | 1 | Controller takes the head burst |
| out_is_cpu | output | 1 | Head burst traffic class |
| out_id | output | 4 | Head burst transaction number |
| out_addr | output | 16 | Head burst address |

## Verification
The checks assume the arbiter holds a presented burst steady until it is accepted, and that the configuration pins change only between traffic sequences, never in the middle of a move. The bench drives every input at the falling edge. Each burst is held until `in_ready` is seen, or withdrawn deliberately before the next rising edge when it is only probing `in_ready`. Each scenario changes configuration only once the queue and backlog have been emptied through the output port. Transaction numbers are chosen so that every eligible and every ineligible case appears with a known delivery order.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  parameter int MRQ_ID_W   = 4;
  parameter int MRQ_ADDR_W = 16;

  typedef struct packed {
    logic                  is_cpu;
    logic [MRQ_ID_W-1:0]   id;
    logic [MRQ_ADDR_W-1:0] addr;
  } mrq_req_t;
endpackage

// File: rtl/mrq_elig.sv
// Marks queue slots whose DMA burst may be parked in the backlog.
module mrq_elig
  import mrq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  mrq_req_t         q [DEPTH],
  input  logic [CW-1:0]    count,
  output logic [DEPTH-1:0] elig
);
  assign elig[0] = 1'b0;  // head never moves

  for (genvar gi = 1; gi < DEPTH; gi++) begin : g_slot
    assign elig[gi] = (CW'(gi) < count) && !q[gi].is_cpu &&
                      (q[0].is_cpu || (q[gi].id != q[0].id));
  end
endmodule

// File: rtl/mrq_store.sv
// In-order queue with pop, masked removal and one tail write per cycle.
module mrq_store
  import mrq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic [DEPTH-1:0] remove,
  input  logic             push,
  input  mrq_req_t         push_data,
  output mrq_req_t         q [DEPTH],
  output logic [CW-1:0]    count
);
  mrq_req_t      nq [DEPTH];
  logic [CW-1:0] ncount;

  always_comb begin
    int w;
    w = 0;
    for (int i = 0; i < DEPTH; i++) nq[i] = q[i];
    for (int i = 0; i < DEPTH; i++) begin
      if ((i < int'(count)) && !(pop && i == 0) && !remove[i]) begin
        nq[w] = q[i];
        w++;
      end
    end
    if (push && w < DEPTH) begin
      nq[w] = push_data;
      w++;
    end
    ncount = CW'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= ncount;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
  end
endmodule

// File: rtl/mrq_backlog.sv
// Side buffer: loads a masked set of queue slots at once, drains one per cycle.
module mrq_backlog
  import mrq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int BL_DEPTH = DEPTH - 1,
  localparam int BCW = $clog2(BL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DEPTH-1:0] load_mask,
  input  mrq_req_t         src [DEPTH],
  input  logic             drain,
  output mrq_req_t         head,
  output logic [BCW-1:0]   count
);
  mrq_req_t       bl [BL_DEPTH];
  mrq_req_t       load_list [BL_DEPTH];
  logic [BCW-1:0] load_cnt;

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < BL_DEPTH; i++) load_list[i] = bl[i];
    for (int i = 0; i < DEPTH; i++) begin
      if (load_mask[i] && n < BL_DEPTH) begin
        load_list[n] = src[i];
        n++;
      end
    end
    load_cnt = BCW'(n);
  end

  assign head = bl[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_cnt;
    else if (drain)  count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < BL_DEPTH; i++) bl[i] <= load_list[i];
    end else if (drain) begin
      for (int i = 0; i < BL_DEPTH - 1; i++) bl[i] <= bl[i+1];
    end
  end
endmodule

// File: rtl/mrq_bypass_queue.sv
module mrq_bypass_queue
  import mrq_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_bypass_en,
  input  logic                  cfg_cpu_first,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_is_cpu,
  input  logic [MRQ_ID_W-1:0]   in_id,
  input  logic [MRQ_ADDR_W-1:0] in_addr,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_is_cpu,
  output logic [MRQ_ID_W-1:0]   out_id,
  output logic [MRQ_ADDR_W-1:0] out_addr
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int BCW = $clog2(DEPTH);

  mrq_req_t         q [DEPTH];
  logic [CW-1:0]    q_count;
  logic [BCW-1:0]   bl_count;
  mrq_req_t         bl_head;
  logic [DEPTH-1:0] elig;
  logic [DEPTH-1:0] move_mask;
  logic             q_space, bl_empty, cpu_in, move_go;
  logic             accept, drain, push, pop;
  mrq_req_t         push_data;

  assign q_space  = q_count < CW'(DEPTH);
  assign bl_empty = bl_count == '0;
  assign cpu_in   = in_valid && in_is_cpu;

  // Move: CPU burst granted, bypass on, CPU ranks first, backlog empty.
  assign move_go   = cfg_bypass_en && cfg_cpu_first && cpu_in && bl_empty && (|elig);
  assign move_mask = move_go ? elig : '0;

  // DMA waits for an empty backlog; CPU needs room or a move.
  assign in_ready = in_is_cpu ? (q_space || move_go) : (bl_empty && q_space);
  assign accept   = in_valid && in_ready;

  // Backlog refills the queue whenever no CPU burst is presented.
  assign drain = !bl_empty && q_space && !cpu_in;
  assign push  = accept || drain;

  always_comb begin
    if (drain) push_data = bl_head;
    else       push_data = '{is_cpu: in_is_cpu, id: in_id, addr: in_addr};
  end

  assign out_valid  = q_count != '0;
  assign out_is_cpu = q[0].is_cpu;
  assign out_id     = q[0].id;
  assign out_addr   = q[0].addr;
  assign pop        = out_valid && out_ready;

  mrq_elig #(.DEPTH(DEPTH)) u_elig (
    .q     (q),
    .count (q_count),
    .elig  (elig)
  );

  mrq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .remove    (move_mask),
    .push      (push),
    .push_data (push_data),
    .q         (q),
    .count     (q_count)
  );

  mrq_backlog #(.DEPTH(DEPTH)) u_backlog (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (move_go),
    .load_mask (move_mask),
    .src       (q),
    .drain     (drain),
    .head      (bl_head),
    .count     (bl_count)
  );
endmodule

// File: rtl/mrq_bypass_queue_chk.sv
module mrq_bypass_queue_chk
  import mrq_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int BCW = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_bypass_en,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  in_is_cpu,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_is_cpu,
  input logic [MRQ_ID_W-1:0]   out_id,
  input logic [MRQ_ADDR_W-1:0] out_addr,
  input logic [CW-1:0]         q_count,
  input logic [BCW-1:0]        bl_count
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= DEPTH);

  p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
                                $stable(out_id) && $stable(out_is_cpu));

  p_bl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bl_count) <= DEPTH - 1);

  p_off_stays_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bypass_en && bl_count == '0 |=> bl_count == '0);

  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bl_count != '0 |=> bl_count <= $past(bl_count));

  p_dma_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_is_cpu && bl_count != '0 |-> !in_ready);

  p_cpu_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_is_cpu && int'(q_count) < DEPTH |-> in_ready);
endmodule

bind mrq_bypass_queue mrq_bypass_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_bypass_en (cfg_bypass_en),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_is_cpu     (in_is_cpu),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_is_cpu    (out_is_cpu),
  .out_id        (out_id),
  .out_addr      (out_addr),
  .q_count       (q_count),
  .bl_count      (bl_count)
);

// File: tb/mrq_bypass_queue_bench.sv
module mrq_bypass_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_bypass_en = 1'b0;
  logic        cfg_cpu_first = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_is_cpu = 1'b0;
  logic [3:0]  in_id = '0;
  logic [15:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_is_cpu;
  logic [3:0]  out_id;
  logic [15:0] out_addr;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  mrq_bypass_queue u_mrq_bypass_queue (
    .clk(clk), .rst_n(rst_n), .cfg_bypass_en(cfg_bypass_en),
    .cfg_cpu_first(cfg_cpu_first), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_cpu(in_is_cpu), .in_id(in_id), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_cpu(out_is_cpu),
    .out_id(out_id), .out_addr(out_addr)
  );

  // {is_cpu, id, addr}: plain FIFO traffic with the bypass disabled
  localparam logic [20:0] TBL [6] = '{
    {1'b0, 4'd1, 16'h0100}, {1'b0, 4'd2, 16'h0101}, {1'b1, 4'd0, 16'h0102},
    {1'b0, 4'd3, 16'h0103}, {1'b1, 4'd0, 16'h0104}, {1'b0, 4'd2, 16'h0105}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input bit cpu, input int id, input int addr, output bit acc);
    @(negedge clk);
    in_valid = 1'b1; in_is_cpu = cpu; in_id = 4'(id); in_addr = 16'(addr);
    #1 acc = in_ready;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic push_wait(input bit cpu, input int id, input int addr, output int stalls);
    @(negedge clk);
    in_valid = 1'b1; in_is_cpu = cpu; in_id = 4'(id); in_addr = 16'(addr);
    #1 stalls = 0;
    while (!in_ready) begin
      stalls++;
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic probe(input bit cpu, input int id, input int addr, output bit rdy);
    @(negedge clk);
    in_valid = 1'b1; in_is_cpu = cpu; in_id = 4'(id); in_addr = 16'(addr);
    #1 rdy = in_ready;
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input int exp_addr, input string req);
    @(negedge clk);
    check(out_valid && int'(out_addr) == exp_addr, req,
          out_valid ? int'(out_addr) : -1, exp_addr);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    bit acc;
    int st;
    int held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    #1 check(!out_valid, "R1 out_valid", int'(out_valid), 0);
    check(in_ready, "R1 in_ready", int'(in_ready), 1);

    // R2: table walk, bypass off, FIFO order and full back-pressure
    for (int i = 0; i < 5; i++) begin
      push(TBL[i][20], int'(TBL[i][19:16]), int'(TBL[i][15:0]), acc);
      check(acc, "R2 accept", int'(acc), 1);
    end
    probe(1'b1, 0, 16'h01ff, acc);
    check(!acc, "R2 full cpu ready", int'(acc), 0);
    for (int i = 0; i < 5; i++) pop_expect(int'(TBL[i][15:0]), "R2 order");
    push(TBL[5][20], int'(TBL[5][19:16]), int'(TBL[5][15:0]), acc);
    pop_expect(int'(TBL[5][15:0]), "R2 order tail");

    // R6, R3: CPU first off -> no move; head stays while not popped
    cfg_bypass_en = 1'b1; cfg_cpu_first = 1'b0;
    push(1'b0, 1, 16'h0010, acc);
    push(1'b0, 2, 16'h0011, acc);
    @(negedge clk); held = int'(out_addr);
    push(1'b1, 0, 16'h0020, acc);
    @(negedge clk);
    check(int'(out_addr) == held, "R3 head held", int'(out_addr), held);
    pop_expect(16'h0010, "R6 order");
    pop_expect(16'h0011, "R6 order");
    pop_expect(16'h0020, "R6 order");

    // R4, R5, R8, R10: move with same-transaction exclusion, DMA stalled
    cfg_cpu_first = 1'b1;
    push(1'b0, 1, 16'h0010, acc);
    push(1'b0, 2, 16'h0011, acc);
    push(1'b0, 1, 16'h0012, acc);
    push(1'b1, 0, 16'h0020, acc);
    check(acc, "R4 cpu accepted", int'(acc), 1);
    push_wait(1'b0, 5, 16'h0030, st);
    check(st == 1, "R8 dma stall cycles", st, 1);
    pop_expect(16'h0010, "R4 head");
    pop_expect(16'h0012, "R5 same txn kept");
    pop_expect(16'h0020, "R4 cpu overtakes");
    pop_expect(16'h0011, "R10 backlog before new dma");
    pop_expect(16'h0030, "R8 new dma last");

    // R7: no move while backlog non-empty
    push(1'b0, 1, 16'h0040, acc);
    push(1'b0, 2, 16'h0041, acc);
    push(1'b0, 3, 16'h0042, acc);
    push(1'b1, 0, 16'h0050, acc);
    idle(1);
    push(1'b1, 0, 16'h0052, acc);
    check(acc, "R7 cpu joins tail", int'(acc), 1);
    idle(2);
    pop_expect(16'h0040, "R7 order");
    pop_expect(16'h0050, "R7 order");
    pop_expect(16'h0041, "R7 order");
    pop_expect(16'h0052, "R7 order");
    pop_expect(16'h0042, "R10 order");

    // R5, R9: full of one transaction -> CPU back-pressured
    for (int i = 0; i < 5; i++) push(1'b0, 5, 16'h0080 + i, acc);
    probe(1'b1, 0, 16'h0090, acc);
    check(!acc, "R9 full no eligible", int'(acc), 0);
    for (int i = 0; i < 5; i++) pop_expect(16'h0080 + i, "R5 no move");

    // R11: full with eligible bursts -> CPU accepted, backlog drains in order
    push(1'b0, 1, 16'h0060, acc);
    for (int i = 1; i < 5; i++) push(1'b0, 2, 16'h0060 + i, acc);
    push(1'b1, 0, 16'h0070, acc);
    check(acc, "R11 cpu into full", int'(acc), 1);
    pop_expect(16'h0060, "R11 order");
    pop_expect(16'h0070, "R11 order");
    for (int i = 1; i < 5; i++) pop_expect(16'h0060 + i, "R10 drain order");
    @(negedge clk);
    check(!out_valid, "R10 empty at end", int'(out_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule